// File: doc/BRIEF.md
# Iterative ARX Block Encryption Core (128-bit key)

This core encrypts one 128-bit block under a 128-bit key with an add-rotate-xor cipher of 24 rounds. It has no substitution tables. Every operation works on 32-bit words and uses only addition modulo 2^32, fixed rotations and XOR. The core computes one complete round in each clock cycle, so a block finishes in 24 busy cycles.

The core stores no table of round keys. It holds a four-word key state and advances it once per round. Each advance adds a rotated schedule constant to every key word and then rotates that word by a fixed amount. The four schedule constants sit in a small ring register. The ring presents the constant for the current round and rotates that constant left by four bits before putting it back at the tail. Each constant is therefore already rotated by the correct amount when its turn comes again.

To use the core, pulse `start` with the plaintext and key present on the inputs. When `done` pulses, read `ct_out`.

Top module: `arx128_enc_core`

## Requirements
- R1: A start sampled while the core is idle is accepted, and the core raises busy on the next cycle. Done is asserted exactly 24 clock edges after the edge that accepted the start, and busy is low in that same cycle.
- R2: Each round maps the words X0..X3 to X0'=rol9((X0^K0)+(X1^K1)), X1'=ror5((X1^K2)+(X2^K3)), X2'=ror3((X2^K4)+(X3^K5)) and X3'=X0. K0..K5 are the round-key words and + is addition modulo 2^32.
- R3: Before round i (counting from 0) is applied, each key-state word Tj (j=0..3) becomes rol_sj(Tj + rol_(i+j)(C[i mod 4])) with s = 1, 3, 6, 11. The round key is (T0, T1, T2, T1, T3, T1), taken from the updated state.
- R4: The schedule constants are C[0]=0xc3efe9db, C[1]=0x44626b02, C[2]=0x79e27c8a and C[3]=0x78df30ec.
- R5: Word k of the plaintext, the key and the ciphertext occupies bits 32k+31 down to 32k, so word 0 is the least significant 32 bits.
- R6: A start pulse while busy is high is ignored. It does not restart the count and does not change the result of the block in progress.
- R7: Done is high for exactly one cycle per block, and busy is never high in a cycle where done is high.
- R8: ct_out changes only in the cycle where done rises. Between completions it holds its value.
- R9: After reset, busy, done and ct_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin encryption; ignored while busy |
| pt_in | input | 128 | Plaintext, word 0 in the low bits |
| key_in | input | 128 | Key, word 0 in the low bits |
| busy | output | 1 | High while rounds are being computed |
| done | output | 1 | One-cycle pulse when the ciphertext is written |
| ct_out | output | 128 | Ciphertext, held until the next completion |

## Verification
The assertions check the control behaviour on every cycle: a start accepted while idle raises busy, the last round produces done with busy low, done lasts a single cycle, busy stays high through the interior rounds, ct_out moves only when done rises, and the round counter stays in range. Only the bench scenarios can show that the arithmetic is correct. They compare ciphertexts against a separate model covering the round function, the key-state update, the constant values and the word packing. They also check that a start held high during a block leaves that block's result unchanged.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 4;
  localparam int BLOCK_W  = WORD_W * N_WORDS;
  localparam int RK_WORDS = 6;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rol(input word_t x, input int unsigned s);
    int unsigned m;
    m = s % WORD_W;
    if (m == 0) return x;
    return (x << m) | (x >> (WORD_W - m));
  endfunction

  function automatic word_t ror(input word_t x, input int unsigned s);
    return rol(x, WORD_W - (s % WORD_W));
  endfunction

  function automatic word_t sched_const(input int unsigned k);
    case (k % 4)
      0: return 32'hc3efe9db;
      1: return 32'h44626b02;
      2: return 32'h79e27c8a;
      default: return 32'h78df30ec;
    endcase
  endfunction

  function automatic int unsigned key_rot(input int unsigned j);
    case (j)
      0: return 1;
      1: return 3;
      2: return 6;
      default: return 11;
    endcase
  endfunction

  function automatic word_t key_word_step(input word_t t, input word_t c, input int unsigned j);
    return rol(t + rol(c, j), key_rot(j));
  endfunction

  function automatic word_t mix_pair(input word_t a, input word_t b,
                                     input word_t ka, input word_t kb);
    return (a ^ ka) + (b ^ kb);
  endfunction
endpackage

// File: rtl/arx_const_ring.sv
module arx_const_ring
  import arx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ADV   = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output word_t head
);
  word_t slot [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[k] <= '0;
      end else if (load) begin
        slot[k] <= rol(sched_const(k), k);
      end else if (step) begin
        if (k == DEPTH - 1) slot[k] <= rol(slot[0], ADV);
        else                slot[k] <= slot[(k + 1) % DEPTH];
      end
    end
  end

  assign head = slot[0];
endmodule

// File: rtl/arx_key_gen.sv
module arx_key_gen
  import arx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      step,
  input  logic [BLOCK_W-1:0]        key_in,
  input  word_t                     cst,
  output logic [RK_WORDS*WORD_W-1:0] rk
);
  word_t t_q [N_WORDS];
  word_t t_d [N_WORDS];

  for (genvar j = 0; j < N_WORDS; j++) begin : g_kw
    assign t_d[j] = key_word_step(t_q[j], cst, j);
    always_ff @(posedge clk) begin
      if (!rst_n)     t_q[j] <= '0;
      else if (load)  t_q[j] <= key_in[j*WORD_W +: WORD_W];
      else if (step)  t_q[j] <= t_d[j];
    end
  end

  assign rk = {t_d[1], t_d[3], t_d[1], t_d[2], t_d[1], t_d[0]};
endmodule

// File: rtl/arx_round.sv
module arx_round
  import arx_pkg::*;
(
  input  logic [BLOCK_W-1:0]         x_in,
  input  logic [RK_WORDS*WORD_W-1:0] rk,
  output logic [BLOCK_W-1:0]         x_out
);
  word_t x [N_WORDS];
  word_t k [RK_WORDS];
  word_t y [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_x
    assign x[i] = x_in[i*WORD_W +: WORD_W];
    assign x_out[i*WORD_W +: WORD_W] = y[i];
  end
  for (genvar i = 0; i < RK_WORDS; i++) begin : g_k
    assign k[i] = rk[i*WORD_W +: WORD_W];
  end

  assign y[0] = rol(mix_pair(x[0], x[1], k[0], k[1]), 9);
  assign y[1] = ror(mix_pair(x[1], x[2], k[2], k[3]), 5);
  assign y[2] = ror(mix_pair(x[2], x[3], k[4], k[5]), 3);
  assign y[3] = x[0];
endmodule

// File: rtl/arx128_enc_core.sv
module arx128_enc_core
  import arx_pkg::*;
#(
  parameter int ROUNDS = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLOCK_W-1:0] pt_in,
  input  logic [BLOCK_W-1:0] key_in,
  output logic               busy,
  output logic               done,
  output logic [BLOCK_W-1:0] ct_out
);
  localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic [CW-1:0]               rnd;
  logic [BLOCK_W-1:0]          x_q;
  logic [BLOCK_W-1:0]          x_nxt;
  logic [RK_WORDS*WORD_W-1:0]  rk;
  word_t                       cst;
  logic                        accept;
  logic                        last_round;

  assign accept     = start & ~busy;
  assign last_round = busy & (rnd == CW'(ROUNDS - 1));

  arx_const_ring #(.DEPTH(4), .ADV(4)) u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .step (busy),
    .head (cst)
  );

  arx_key_gen u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (busy),
    .key_in(key_in),
    .cst   (cst),
    .rk    (rk)
  );

  arx_round u_rnd (
    .x_in (x_q),
    .rk   (rk),
    .x_out(x_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      rnd    <= '0;
      x_q    <= '0;
      ct_out <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        rnd  <= '0;
        x_q  <= pt_in;
      end else if (busy) begin
        x_q <= x_nxt;
        rnd <= rnd + 1'b1;
        if (last_round) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          ct_out <= x_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/arx128_enc_chk.sv
module arx128_enc_chk #(
  parameter int ROUNDS = 24,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [127:0]  ct_out,
  input logic [CW-1:0] rnd,
  input logic          last_round
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  // R1
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> done && !busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_round |=> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ct_out));
  // R1
  rnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(rnd) < ROUNDS));
endmodule

bind arx128_enc_core arx128_enc_chk #(.ROUNDS(ROUNDS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ct_out    (ct_out),
  .rnd       (rnd),
  .last_round(last_round)
);

// File: tb/sim_arx128_enc_core.sv
module sim_arx128_enc_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] pt_in = '0;
  logic [127:0] key_in = '0;
  logic         busy;
  logic         done;
  logic [127:0] ct_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  arx128_enc_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pt_in(pt_in),
    .key_in(key_in), .busy(busy), .done(done), .ct_out(ct_out)
  );

  // one-bit-at-a-time rotation, independent of the RTL formulation
  function automatic logic [31:0] brol(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = v;
    for (int q = 0; q < (n % 32); q++) r = {r[30:0], r[31]};
    return r;
  endfunction

  function automatic logic [31:0] cval(input int k);
    logic [31:0] tab [4];
    tab[0] = 32'hc3efe9db; tab[1] = 32'h44626b02;
    tab[2] = 32'h79e27c8a; tab[3] = 32'h78df30ec;
    return tab[k % 4];
  endfunction

  function automatic logic [127:0] model(input logic [127:0] p, input logic [127:0] k);
    logic [31:0] x [4];
    logic [31:0] t [4];
    logic [31:0] nx [4];
    int sh [4];
    sh[0] = 1; sh[1] = 3; sh[2] = 6; sh[3] = 11;
    for (int w = 0; w < 4; w++) begin
      x[w] = p[32*w +: 32];
      t[w] = k[32*w +: 32];
    end
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 4; j++) t[j] = brol(t[j] + brol(cval(i % 4), i + j), sh[j]);
      nx[0] = brol((x[0] ^ t[0]) + (x[1] ^ t[1]), 9);
      nx[1] = brol((x[1] ^ t[2]) + (x[2] ^ t[1]), 27);
      nx[2] = brol((x[2] ^ t[3]) + (x[3] ^ t[1]), 29);
      nx[3] = x[0];
      for (int w = 0; w < 4; w++) x[w] = nx[w];
    end
    return {x[3], x[2], x[1], x[0]};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start at a negedge, then count edges until done is seen
  task automatic run(input logic [127:0] p, input logic [127:0] k, input bit hold_start,
                     output int lat);
    @(negedge clk);
    pt_in = p; key_in = k; start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (hold_start) begin
        pt_in = ~p; key_in = k ^ 128'h1;
      end
      if (done) start = 1'b0;
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int lat;
    logic [127:0] p, k, prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", {127'd0, busy}, 128'd0);
    check("R9 done", {127'd0, done}, 128'd0);
    check("R9 ct_out", ct_out, 128'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: all-zero vector and latency
    run(128'd0, 128'd0, 1'b0, lat);
    check("R1 latency", 128'(lat), 128'd24);
    check("R2 R3 R4 zero block", ct_out, model(128'd0, 128'd0));

    // R5: only word 0 set, then only word 3 set
    p = 128'h0000_0000_0000_0000_0000_0000_0102_0304;
    k = 128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f;
    run(p, k, 1'b0, lat);
    check("R5 low word", ct_out, model(p, k));
    p = 128'h0102_0304_0000_0000_0000_0000_0000_0000;
    run(p, k, 1'b0, lat);
    check("R5 high word", ct_out, model(p, k));

    // R2 R3: all ones
    run('1, '1, 1'b0, lat);
    check("R2 R3 all ones", ct_out, model('1, '1));

    // R8: ct holds, done stays low
    prev = ct_out;
    @(negedge clk);
    check("R7 done single", {127'd0, done}, 128'd0);
    repeat (6) @(negedge clk);
    check("R8 ct hold", ct_out, prev);

    // R6: start held high through the block with changing inputs
    p = {$urandom, $urandom, $urandom, $urandom};
    k = {$urandom, $urandom, $urandom, $urandom};
    run(p, k, 1'b1, lat);
    check("R6 latency", 128'(lat), 128'd24);
    check("R6 result", ct_out, model(p, k));
    check("R7 busy low at done", {127'd0, busy}, 128'd0);

    // R2 R3 R4: random blocks
    for (int n = 0; n < 20; n++) begin
      p = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      run(p, k, 1'b0, lat);
      check("R1 rand latency", 128'(lat), 128'd24);
      check("R2 R3 rand block", ct_out, model(p, k));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule